// File: doc/BRIEF.md
# Shared Word Memory with Atomic Exchange and Lock Helpers

This block is a small word memory shared by several requester ports. Each port can read a word, write a word, or exchange a word. An exchange writes a new value and hands back the value that was there before, all inside one grant. A round-robin arbiter admits a single request per cycle. Two exchanges aimed at the same word therefore happen in order, and never overlap.

Each port also has a lock helper. When started, the helper spins on a lock word. A lock word reads 0 when free and 1 when held. The helper exchanges a 1 into that word over and over until an exchange hands back 0, and at that point the caller owns the lock. To give the lock up, the owner writes 0 with a plain store. Plain read-then-write sequences from two ports get no such protection, and two such sequences can interleave.

Requests use valid/ready. Once a port raises valid, it must hold valid and the request fields steady until it sees ready high at a clock edge. Ready is high only in the cycle the port is granted. Responses carry no back-pressure: the port must take the response in the cycle it appears.

Top module: `swap_lock_mem`

## Requirements
- R1: After reset every word reads 0, no response is valid, and no lock helper is busy.
- R2: Operation codes are: 0 = read, 1 = write, 2 = exchange, 3 = read. A write stores the write data. Every response carries the contents the word held before the grant, so a read of a word that was just written returns the written value.
- R3: An exchange returns the old word and stores the new value within its own grant. When two ports exchange the same word at the same time, exactly one of them sees the original value, the other sees the first port's value, and the word ends up holding the second port's value.
- R4: At most one port is granted per cycle, and only a port presenting a request can be granted. Ready is high only on the granted port. A port presenting a request must hold it until ready.
- R5: A response is valid for exactly one cycle, namely the cycle after the grant, on the granted port only.
- R6: Arbitration is round-robin. Out of reset, port 0 ranks first. After port p is granted, the search starts at port p+1. A port that keeps requesting is therefore never granted twice in a row while another port is waiting.
- R7: A start pulse on an idle helper makes the helper issue exchanges of 1 to its lock address. It issues another exchange after every response that is nonzero. The done pulse is raised in the cycle of the response that returned 0. While the helper is busy, the port's own requests see ready low and have no effect.
- R8: When two ports contend for one lock, and each one updates a shared counter only while holding the lock and then releases it by storing 0, no update is lost and no two ports are ever inside the critical section together.
- R9: If two ports each read a word before either writes it back, a read-add-write from each port leaves the word incremented only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_ready | output | NPORTS | Request accepted this cycle |
| req_op | input | NPORTS x 2 | Operation code per port |
| req_addr | input | NPORTS x ADDR_W | Word address per port |
| req_wdata | input | NPORTS x DATA_W | Write or exchange data per port |
| rsp_valid | output | NPORTS | Response valid, one cycle after the grant |
| rsp_data | output | NPORTS x DATA_W | Word contents before the granted operation |
| acq_start | input | NPORTS | Pulse that starts the lock helper of a port |
| acq_addr | input | NPORTS x ADDR_W | Lock word address, captured on start |
| acq_busy | output | NPORTS | Helper is spinning on its lock |
| acq_done | output | NPORTS | Pulse when the helper has taken the lock |

## Verification
The bench goes after simultaneous exchanges to one word. A design that split the read from the write would give both ports the original value. It checks that a port spinning on a held lock cannot starve the holder. A fixed-priority or non-rotating arbiter would hang the lock-counter test, or would show repeated grants that the model flags. It checks that a port whose helper is busy cannot write through its own request lines, and a leaking mux would corrupt a word that should stay zero. The unprotected read-add-write case must leave the count at 1, and the lock-protected case must reach the full total. An off-by-one in response timing or in the helper's retry decision shows up as a mismatch against the per-cycle model.

// File: rtl/slm_pkg.sv
package slm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_LOAD2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    H_IDLE  = 2'd0,
    H_ISSUE = 2'd1,
    H_WAIT  = 2'd2
  } hstate_e;
endpackage

// File: rtl/slm_rr_arbiter.sv
module slm_rr_arbiter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] pick;
  logic [IW-1:0] enc;
  logic          found;

  // search starts one past the last winner
  always_comb begin
    grant = '0;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      pick = IW'((32'(last_q) + 32'(k)) % 32'(N));
      if (!found && valid[pick]) begin
        grant[pick] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    enc = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) enc = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (|grant) begin
      last_q <= enc;
    end
  end

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~valid) == '0);

  // R6: a waiting port means the previous winner cannot win again next cycle
  assert_no_repeat_while_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(valid & ~grant)) |=> ((grant & $past(grant)) == '0));
endmodule

// File: rtl/slm_core.sv
module slm_core
  import slm_pkg::*;
#(
  parameter int N      = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                grant,
  input  logic [N-1:0][1:0]           op,
  input  logic [N-1:0][ADDR_W-1:0]    addr,
  input  logic [N-1:0][DATA_W-1:0]    wdata,
  output logic [N-1:0]                rsp_valid,
  output logic [N-1:0][DATA_W-1:0]    rsp_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [1:0]        sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wd;
  logic [DATA_W-1:0] old_word;
  logic              do_write;

  // OR-mux of the single granted request
  always_comb begin
    sel_op   = '0;
    sel_addr = '0;
    sel_wd   = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        sel_op   = sel_op | op[i];
        sel_addr = sel_addr | addr[i];
        sel_wd   = sel_wd | wdata[i];
      end
    end
    old_word = mem_q[sel_addr];
    do_write = (|grant) && (sel_op == OP_STORE || sel_op == OP_SWAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= grant;
      if (do_write) mem_q[sel_addr] <= sel_wd;
      for (int i = 0; i < N; i++) begin
        if (grant[i]) rsp_data[i] <= old_word;
      end
    end
  end

  assert_rsp_follows_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(grant)));
endmodule

// File: rtl/slm_lock_helper.sv
module slm_lock_helper
  import slm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              gnt,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              h_valid,
  output logic [ADDR_W-1:0] h_addr,
  output logic              busy,
  output logic              done
);
  hstate_e           state_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= H_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        H_IDLE: if (start) begin
          state_q <= H_ISSUE;
          addr_q  <= lock_addr;
        end
        H_ISSUE: if (gnt) state_q <= H_WAIT;
        H_WAIT: if (rsp_valid) state_q <= (rsp_data == '0) ? H_IDLE : H_ISSUE;
        default: state_q <= H_IDLE;
      endcase
    end
  end

  assign h_valid = (state_q == H_ISSUE);
  assign h_addr  = addr_q;
  assign busy    = (state_q != H_IDLE);
  assign done    = (state_q == H_WAIT) && rsp_valid && (rsp_data == '0);

  // R7: the helper keeps asking until it is served
  assert_helper_holds_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && !gnt) |=> h_valid);

  assert_done_only_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/swap_lock_mem.sv
module swap_lock_mem
  import slm_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0]             req_valid,
  output logic [NPORTS-1:0]             req_ready,
  input  logic [NPORTS-1:0][1:0]        req_op,
  input  logic [NPORTS-1:0][ADDR_W-1:0] req_addr,
  input  logic [NPORTS-1:0][DATA_W-1:0] req_wdata,
  output logic [NPORTS-1:0]             rsp_valid,
  output logic [NPORTS-1:0][DATA_W-1:0] rsp_data,
  input  logic [NPORTS-1:0]             acq_start,
  input  logic [NPORTS-1:0][ADDR_W-1:0] acq_addr,
  output logic [NPORTS-1:0]             acq_busy,
  output logic [NPORTS-1:0]             acq_done
);
  logic [NPORTS-1:0]             eff_valid;
  logic [NPORTS-1:0][1:0]        eff_op;
  logic [NPORTS-1:0][ADDR_W-1:0] eff_addr;
  logic [NPORTS-1:0][DATA_W-1:0] eff_wd;
  logic [NPORTS-1:0]             grant;
  logic [NPORTS-1:0]             h_valid;
  logic [NPORTS-1:0][ADDR_W-1:0] h_addr;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    slm_lock_helper #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) helper_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (acq_start[p]),
      .lock_addr (acq_addr[p]),
      .gnt       (grant[p]),
      .rsp_valid (rsp_valid[p]),
      .rsp_data  (rsp_data[p]),
      .h_valid   (h_valid[p]),
      .h_addr    (h_addr[p]),
      .busy      (acq_busy[p]),
      .done      (acq_done[p])
    );

    // helper owns the port while it spins
    assign eff_valid[p] = acq_busy[p] ? h_valid[p] : req_valid[p];
    assign eff_op[p]    = acq_busy[p] ? OP_SWAP : req_op[p];
    assign eff_addr[p]  = acq_busy[p] ? h_addr[p] : req_addr[p];
    assign eff_wd[p]    = acq_busy[p] ? DATA_W'(1) : req_wdata[p];
    assign req_ready[p] = grant[p] & ~acq_busy[p];

    assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_ready[p] && !acq_busy[p]) |=> req_valid[p]);
  end

  slm_rr_arbiter #(
    .N (NPORTS)
  ) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (eff_valid),
    .grant (grant)
  );

  slm_core #(
    .N      (NPORTS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .op        (eff_op),
    .addr      (eff_addr),
    .wdata     (eff_wd),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: tb/swap_lock_mem_tb_top.sv
`timescale 1ns/1ps
module swap_lock_mem_tb_top;
  localparam int NP    = 2;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]         req_valid, req_ready, rsp_valid, acq_start, acq_busy, acq_done;
  logic [NP-1:0][1:0]    req_op;
  logic [NP-1:0][AW-1:0] req_addr, acq_addr;
  logic [NP-1:0][DW-1:0] req_wdata, rsp_data;

  logic          b_valid [NP];
  logic [1:0]    b_op    [NP];
  logic [AW-1:0] b_addr  [NP];
  logic [DW-1:0] b_wd    [NP];
  logic          b_start [NP];
  logic [AW-1:0] b_aaddr [NP];

  for (genvar p = 0; p < NP; p++) begin : g_drv
    assign req_valid[p] = b_valid[p];
    assign req_op[p]    = b_op[p];
    assign req_addr[p]  = b_addr[p];
    assign req_wdata[p] = b_wd[p];
    assign acq_start[p] = b_start[p];
    assign acq_addr[p]  = b_aaddr[p];
  end

  swap_lock_mem #(.NPORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .acq_start(acq_start), .acq_addr(acq_addr),
    .acq_busy(acq_busy), .acq_done(acq_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mem [DEPTH];
  int m_last;
  bit m_rv  [NP];
  int m_rd  [NP];
  int m_hs  [NP];   // 0 idle, 1 issuing, 2 waiting
  int m_ha  [NP];

  always @(negedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_last = NP - 1;
      for (int p = 0; p < NP; p++) begin
        m_rv[p] = 0; m_rd[p] = 0; m_hs[p] = 0; m_ha[p] = 0;
      end
    end else begin
      bit ev [NP];
      int eo [NP];
      int ea [NP];
      int ew [NP];
      bit nrv [NP];
      int g;
      bit bad;
      bad = 0;
      for (int p = 0; p < NP; p++) begin
        if (m_hs[p] == 1) begin
          ev[p] = 1; eo[p] = 2; ea[p] = m_ha[p]; ew[p] = 1;
        end else if (m_hs[p] == 2) begin
          ev[p] = 0; eo[p] = 0; ea[p] = 0; ew[p] = 0;
        end else begin
          ev[p] = req_valid[p]; eo[p] = int'(req_op[p]);
          ea[p] = int'(req_addr[p]); ew[p] = int'(req_wdata[p]);
        end
      end
      g = -1;
      for (int k = 1; k <= NP; k++) begin
        int idx;
        idx = (m_last + k) % NP;
        if (g < 0 && ev[idx]) g = idx;
      end
      for (int p = 0; p < NP; p++) begin
        bit er, ed;
        er = (m_hs[p] == 0) && (g == p);
        ed = (m_hs[p] == 2) && m_rv[p] && (m_rd[p] == 0);
        if (req_ready[p] !== er) begin
          bad = 1; $display("FAIL R4 R6 ready port %0d actual=%0b expected=%0b", p, req_ready[p], er);
        end
        if (rsp_valid[p] !== m_rv[p]) begin
          bad = 1; $display("FAIL R5 rsp_valid port %0d actual=%0b expected=%0b", p, rsp_valid[p], m_rv[p]);
        end
        if (m_rv[p] && int'(rsp_data[p]) != m_rd[p]) begin
          bad = 1; $display("FAIL R2 R3 rsp_data port %0d actual=%0h expected=%0h", p, rsp_data[p], m_rd[p]);
        end
        if (acq_busy[p] !== (m_hs[p] != 0)) begin
          bad = 1; $display("FAIL R7 busy port %0d actual=%0b expected=%0b", p, acq_busy[p], m_hs[p] != 0);
        end
        if (acq_done[p] !== ed) begin
          bad = 1; $display("FAIL R7 done port %0d actual=%0b expected=%0b", p, acq_done[p], ed);
        end
      end
      n_checks++;
      if (bad) n_fail++;
      // helper transitions use the pre-edge response values
      for (int p = 0; p < NP; p++) begin
        case (m_hs[p])
          0: if (acq_start[p]) begin m_hs[p] = 1; m_ha[p] = int'(acq_addr[p]); end
          1: if (g == p) m_hs[p] = 2;
          2: if (m_rv[p]) m_hs[p] = (m_rd[p] == 0) ? 0 : 1;
          default: m_hs[p] = 0;
        endcase
      end
      for (int p = 0; p < NP; p++) nrv[p] = 0;
      if (g >= 0) begin
        int old;
        old = m_mem[ea[g]];
        if (eo[g] == 1 || eo[g] == 2) m_mem[ea[g]] = ew[g] & 16'hFFFF;
        nrv[g] = 1;
        m_rd[g] = old;
        m_last = g;
      end
      for (int p = 0; p < NP; p++) m_rv[p] = nrv[p];
    end
  end

  // ---------------- port tasks ----------------
  task automatic port_op(input int p, input int op, input int a, input int wd, output int rd);
    @(posedge clk); #1;
    b_valid[p] = 1'b1; b_op[p] = 2'(op); b_addr[p] = AW'(a); b_wd[p] = DW'(wd);
    @(negedge clk);
    while (!req_ready[p]) @(negedge clk);
    @(posedge clk); #1;
    b_valid[p] = 1'b0;
    @(negedge clk);
    rd = int'(rsp_data[p]);
  endtask

  task automatic acquire(input int p, input int a);
    @(posedge clk); #1;
    b_start[p] = 1'b1; b_aaddr[p] = AW'(a);
    @(posedge clk); #1;
    b_start[p] = 1'b0;
    @(negedge clk);
    while (!acq_done[p]) @(negedge clk);
  endtask

  localparam int LOCK = 1;
  localparam int CNT  = 2;
  localparam int CNT2 = 5;
  localparam int XW   = 7;
  localparam int SW   = 9;
  localparam int ITER = 5;

  int in_cs = 0;

  task automatic crit_worker(input int p);
    int v, d;
    for (int i = 0; i < ITER; i++) begin
      acquire(p, LOCK);
      in_cs++;
      check(in_cs == 1, "R8 mutual exclusion", in_cs, 1);
      port_op(p, 0, CNT, 0, v);
      port_op(p, 1, CNT, v + 1, d);
      in_cs--;
      port_op(p, 1, LOCK, 0, d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, r1, v0, v1, d;
    for (int p = 0; p < NP; p++) begin
      b_valid[p] = 0; b_op[p] = 0; b_addr[p] = 0; b_wd[p] = 0;
      b_start[p] = 0; b_aaddr[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rsp_valid == '0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    check(acq_busy == '0, "R1 helpers idle after reset", int'(acq_busy), 0);
    port_op(0, 0, 3, 0, r0);
    check(r0 == 0, "R1 word 3 reads zero", r0, 0);
    port_op(1, 0, 15, 0, r1);
    check(r1 == 0, "R1 word 15 reads zero", r1, 0);

    // R2 store/load, op 3 reads
    port_op(0, 1, 3, 16'h1234, r0);
    check(r0 == 0, "R2 store returns old word", r0, 0);
    port_op(1, 0, 3, 0, r1);
    check(r1 == 16'h1234, "R2 load returns stored", r1, 16'h1234);
    port_op(1, 3, 3, 16'hBEEF, r1);
    check(r1 == 16'h1234, "R2 op 3 reads", r1, 16'h1234);
    port_op(0, 0, 3, 0, r0);
    check(r0 == 16'h1234, "R2 op 3 does not write", r0, 16'h1234);

    // R5 single-cycle response
    @(negedge clk);
    check(rsp_valid == '0, "R5 response lasts one cycle", int'(rsp_valid), 0);

    // R3 swap and contended swap
    port_op(0, 2, SW, 16'h00AB, r0);
    check(r0 == 0, "R3 swap returns old", r0, 0);
    fork
      port_op(0, 2, SW, 16'h1111, r0);
      port_op(1, 2, SW, 16'h2222, r1);
    join
    check((r0 == 16'h00AB) != (r1 == 16'h00AB), "R3 exactly one sees original", r0, r1);
    check((r0 == 16'h00AB) ? (r1 == 16'h1111) : (r0 == 16'h2222), "R3 loser sees winner value", r0, r1);
    port_op(0, 0, SW, 0, d);
    check(d == ((r0 == 16'h00AB) ? 16'h2222 : 16'h1111), "R3 final word", d, (r0 == 16'h00AB) ? 16'h2222 : 16'h1111);

    // R6 alternating grants under steady contention (model also compares ready each cycle)
    fork
      for (int i = 0; i < 4; i++) port_op(0, 0, i, 0, r0);
      for (int i = 0; i < 4; i++) port_op(1, 0, i, 0, r1);
    join
    check(1'b1, "R6 contention completed", 1, 1);

    // R9 unprotected read-add-write loses an update
    fork
      port_op(0, 0, CNT2, 0, v0);
      port_op(1, 0, CNT2, 0, v1);
    join
    fork
      port_op(0, 1, CNT2, v0 + 1, r0);
      port_op(1, 1, CNT2, v1 + 1, r1);
    join
    port_op(0, 0, CNT2, 0, d);
    check(v0 == 0 && v1 == 0, "R9 both read zero", v0 + v1, 0);
    check(d == 1, "R9 lost update leaves count 1", d, 1);

    // R7 busy helper blocks the port's own requests
    acquire(0, LOCK);
    @(posedge clk); #1;
    b_start[1] = 1'b1; b_aaddr[1] = AW'(LOCK);
    @(posedge clk); #1;
    b_start[1] = 1'b0;
    b_valid[1] = 1'b1; b_op[1] = 2'd1; b_addr[1] = AW'(XW); b_wd[1] = 16'h0055;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(req_ready[1] == 1'b0, "R7 ready low while helper busy", int'(req_ready[1]), 0);
    end
    check(acq_busy[1] == 1'b1, "R7 helper still spinning", int'(acq_busy[1]), 1);
    @(posedge clk); #1;
    b_valid[1] = 1'b0;
    port_op(0, 1, LOCK, 0, d);
    check(d == 1, "R7 lock was held", d, 1);
    @(negedge clk);
    while (!acq_done[1]) @(negedge clk);
    port_op(1, 1, LOCK, 0, d);
    port_op(0, 0, XW, 0, d);
    check(d == 0, "R7 blocked store had no effect", d, 0);

    // R8 lock-protected counter
    fork
      crit_worker(0);
      crit_worker(1);
    join
    port_op(0, 0, CNT, 0, d);
    check(d == 2 * ITER, "R8 counter total", d, 2 * ITER);
    port_op(1, 0, LOCK, 0, d);
    check(d == 0, "R8 lock released", d, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule